// File: doc/BRIEF.md
# Peripheral Interrupt Controller

This block gathers thirty-two peripheral interrupt sources onto a single interrupt line for a processor. Each source owns one bit in a status word and one bit in a mask word. Most status bits are the live level of their source input. Two bits, 10 and 11, are different: a one-cycle pulse from the serial transmit-done and receive-done events latches each of them. Software clears them by writing ones.

The status word ANDed with the mask word forms the pending vector. The interrupt line is the registered OR of that vector. A service word reports the lowest-numbered pending source and a valid flag. A spurious flag rises while the line is still asserted but the pending vector has already emptied. The line stays asserted for one cycle after the vector empties.

Software starts the block by writing zero to the mask and all ones to the status word. The register port is plain control: a write strobe with an address and data, and a combinational read selected by a separate address. There is no valid/ready handshake because the port carries no data stream, and it never stalls.

Top module: `periph_irq_ctrl`

## Requirements
- R1: After reset the mask word is zero, both latched event bits are zero and `irq_o` is low.
- R2: A write with `wr_addr_i` = 1 loads the whole mask word, and the new value is readable from the next cycle.
- R3: Every status bit except 10 and 11 equals its `src_level_i` bit in the same cycle, and writes to those bits have no effect.
- R4: Status bit 10 is set by `evt_pulse_i[0]` and bit 11 by `evt_pulse_i[1]`. Each stays set until it is cleared. `src_level_i[10]` and `src_level_i[11]` are ignored.
- R5: A write with `wr_addr_i` = 0 clears latched bit 10 or 11 where the data bit is 1. Where the data bit is 0 the latched bit is left unchanged.
- R6: When an event pulse and a clearing write reach the same latched bit in one cycle, the bit ends up set.
- R7: The pending vector is status AND mask. The service word carries the index of the lowest set pending bit in bits 4:0 and a valid flag in bit 8.
- R8: When nothing is pending, the service word's valid flag (bit 8) is 0 and its index is 0.
- R9: `irq_o` equals the OR of the pending vector as it stood one clock earlier.
- R10: `spurious_o` is high exactly when `irq_o` is high and the current pending vector is empty.
- R11: Reads are combinational and selected by `rd_addr_i`: 0 gives status, 1 gives mask, 2 gives the service word and 3 gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_level_i | input | 32 | Level inputs of the sources |
| evt_pulse_i | input | 2 | One-cycle event pulses for status bits 10 (bit 0) and 11 (bit 1) |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write target: 0 status, 1 mask |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read select |
| rd_data_o | output | 32 | Read data |
| irq_o | output | 1 | Registered interrupt line |
| spurious_o | output | 1 | Line asserted with nothing pending |

## Verification
The hardest situation to produce is the spurious flag, because it exists only in the single cycle after the pending vector empties while the registered line is still high. The bench raises a masked-in source, waits for `irq_o`, then drops the source between edges and samples before the next edge. The second hard case is an event and a clearing write landing on the same latched bit in one cycle. The bench drives both on the same edge and reads the status word afterwards.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    PIC_A_STAT = 2'd0,
    PIC_A_MASK = 2'd1,
    PIC_A_SVC  = 2'd2,
    PIC_A_NONE = 2'd3
  } pic_addr_e;

  localparam int unsigned PIC_SVC_VLD_BIT = 8;
endpackage

// File: rtl/pic_evt_latch.sv
module pic_evt_latch #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;
      else if (clr_i[g]) q <= 1'b0;
    end
    assign q_o[g] = q;

    // R4 R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> q_o[g]);
    // R5
    clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !q_o[g]);
  end
endmodule

// File: rtl/pic_lowest.sv
module pic_lowest #(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/periph_irq_ctrl.sv
module periph_irq_ctrl #(
  parameter int unsigned NSRC     = 32,
  parameter int unsigned EVT_BASE = 10,
  parameter int unsigned N_EVT    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_level_i,
  input  logic [N_EVT-1:0] evt_pulse_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [NSRC-1:0]  wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [NSRC-1:0]  rd_data_o,
  output logic             irq_o,
  output logic             spurious_o
);
  import pic_pkg::*;
  localparam int unsigned IDXW = $clog2(NSRC);

  logic [NSRC-1:0]  mask_q, status, pend, svc_word;
  logic [N_EVT-1:0] evt_q, evt_clr;
  logic [IDXW-1:0]  sel_idx;
  logic             sel_any, irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (wr_en_i && wr_addr_i == PIC_A_MASK) mask_q <= wr_data_i;
  end

  assign evt_clr = (wr_en_i && wr_addr_i == PIC_A_STAT) ?
                   wr_data_i[EVT_BASE +: N_EVT] : '0;

  pic_evt_latch #(.N(N_EVT)) u_evt (
    .clk(clk), .rst_n(rst_n), .set_i(evt_pulse_i), .clr_i(evt_clr), .q_o(evt_q)
  );

  always_comb begin
    status = src_level_i;
    status[EVT_BASE +: N_EVT] = evt_q;
  end

  assign pend = status & mask_q;

  pic_lowest #(.W(NSRC), .IW(IDXW)) u_sel (
    .vec_i(pend), .idx_o(sel_idx), .any_o(sel_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= sel_any;
  end

  assign irq_o      = irq_q;
  assign spurious_o = irq_q & ~sel_any;

  always_comb begin
    svc_word = '0;
    svc_word[IDXW-1:0] = sel_idx;
    svc_word[PIC_SVC_VLD_BIT] = sel_any;
  end

  always_comb begin
    case (rd_addr_i)
      PIC_A_STAT: rd_data_o = status;
      PIC_A_MASK: rd_data_o = mask_q;
      PIC_A_SVC:  rd_data_o = svc_word;
      default:    rd_data_o = '0;
    endcase
  end

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == PIC_A_MASK) |=> mask_q == $past(wr_data_i));
  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & mask_q)) |=> irq_o);
  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status & mask_q)) |=> !irq_o);
  // R7
  sel_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_any |-> (pend[sel_idx] && ((pend & ((NSRC'(1) << sel_idx) - NSRC'(1))) == '0)));
  // R10
  spur_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spurious_o |-> (irq_o && (status & mask_q) == '0));
endmodule

// File: tb/periph_irq_ctrl_tb.sv
`timescale 1ns/1ps
module periph_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_level = '0;
  logic [1:0]  evt = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq, spur;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  periph_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_level_i(src_level), .evt_pulse_i(evt),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq), .spurious_o(spur)
  );

  localparam int NT = 7;
  localparam logic [31:0] T_SRC  [NT] = '{32'h0000_0001, 32'h8000_0000, 32'h8000_0010,
    32'h0000_00F0, 32'hFFFF_FFFF, 32'h00F0_F000, 32'h0000_0400};
  localparam logic [31:0] T_MASK [NT] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000,
    32'h0000_00C0, 32'h0000_0000, 32'hFFFF_0000, 32'hFFFF_FFFF};
  localparam logic [31:0] T_SVC  [NT] = '{32'h100, 32'h11F, 32'h11F,
    32'h106, 32'h000, 32'h114, 32'h000};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(2'd1, d); check("R1 mask", d, 32'h0);
    rd(2'd0, d); check("R1 latched", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    // R11 unused address
    rd(2'd3, d); check("R11 addr3", d, 32'h0);

    for (int i = 0; i < NT; i++) begin
      wr(2'd1, T_MASK[i]);
      src_level = T_SRC[i];
      rd(2'd1, d); check("R2 mask", d, T_MASK[i]);
      rd(2'd2, d); check("R7 R8 svc", d, T_SVC[i]);
      @(posedge clk); #1;
      check("R9 irq", {31'b0, irq}, {31'b0, T_SVC[i][8]});
    end

    // R3 level bits follow source and ignore writes
    wr(2'd1, 32'hFFFF_FFFF);
    src_level = 32'h0000_0003;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R3 R4 status", d, 32'h0000_0003);

    // R10 spurious window
    @(posedge clk); #1;
    check("R9 irq up", {31'b0, irq}, 32'h1);
    src_level = '0; #1;
    check("R10 spurious", {31'b0, spur}, 32'h1);
    @(posedge clk); #1;
    check("R10 spurious clear", {31'b0, spur, irq}, 32'h0);

    // R4 event latch
    evt = 2'b01; @(posedge clk); #1; evt = 2'b00;
    rd(2'd0, d); check("R4 bit10 set", d, 32'h0000_0400);
    rd(2'd2, d); check("R4 svc10", d, 32'h10A);
    evt = 2'b10; @(posedge clk); #1; evt = 2'b00;
    rd(2'd0, d); check("R4 bit11 set", d, 32'h0000_0C00);
    // R5 clear only bit 11
    wr(2'd0, 32'h0000_0800);
    rd(2'd0, d); check("R5 clr11", d, 32'h0000_0400);
    // R6 event wins over clear
    evt = 2'b01; wr(2'd0, 32'h0000_0400); evt = 2'b00;
    rd(2'd0, d); check("R6 evt wins", d, 32'h0000_0400);
    wr(2'd0, 32'h0000_0400);
    rd(2'd0, d); check("R5 clr10", d, 32'h0);

    // R1 reset mid-run
    wr(2'd1, 32'h1234_5678);
    evt = 2'b11; @(posedge clk); #1; evt = 2'b00;
    rst_n = 1'b0; #2; rst_n = 1'b1; #1;
    rd(2'd1, d); check("R1 mask after reset", d, 32'h0);
    rd(2'd0, d); check("R1 latched after reset", d, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule